// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host side of a three-wire link to a 10-bit successive-approximation converter. A single-cycle start request, a two-bit mode request and a clock-divider value set it running. It drives an active-low chip select and a serial clock that both idle high. It samples the converter's serial data line and returns the 10-bit straight-binary result with a one-cycle strobe. The sample is taken on the chip-select falling edge, so the returned word always belongs to the frame that just ended.

The controller also models the converter's power state. A frame cut short after four clock cycles puts the converter in a light sleep. Two short frames in a row put it into deep sleep. The controller inserts full-length dummy frames, and after deep sleep or an unknown state it adds a power-up wait, so that a result is only reported once the converter is awake. Between frames, chip select is held high for a programmable quiet time.

Top module: `sar_readout_ctrl`

## Requirements
- R1: During and right after reset, chip select is high, serial clock is high, busy, done and valid are low, and the power state reads 0 (unknown).
- R2: The serial clock is high whenever chip select is high. While a frame runs, each clock half-period lasts max(div_i/2, 1) system clocks, with odd values rounded down.
- R3: A full frame has exactly 16 serial-clock falling edges between the chip-select falling and rising edges. The data line is sampled on serial-clock rising edges 2 through 11, counted from 1. The first sample is the result MSB.
- R4: A request in mode 0 (mode 3 is treated the same) ends with done and valid high together for one cycle. The result equals the code converted in the last frame of that request.
- R5: A mode 1 request with the power state at 1 (awake) runs one frame of exactly 4 falling edges. It ends without valid, and the power state becomes 2 (light sleep).
- R6: A mode 2 request runs short 4-edge frames until two have occurred back to back: two frames when awake, one when in light sleep. The power state becomes 3 (deep sleep).
- R7: A mode 0 request in light sleep runs a 16-edge dummy frame and then the real frame. Only the second frame produces the result.
- R8: A mode 0 request in deep sleep or in the unknown state runs a 16-edge dummy frame. Chip select then stays high at least PWRUP_CYC system clocks before the real frame begins.
- R9: Between any two frames, chip select stays high at least max(quiet_i, 1) system clocks.
- R10: A request whose mode matches the present sleep state (mode 1 in light sleep, mode 2 in deep sleep) runs no frame. It still ends with one done pulse, without valid, and leaves the power state unchanged.
- R11: A start pulse that arrives while busy is ignored. No extra frame follows, and the power state stays as the first request left it.
- R12: Done is high for exactly one cycle per request. Valid is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request pulse |
| mode_i | input | 2 | 0/3 convert, 1 light sleep, 2 deep sleep |
| div_i | input | DIV_W | Serial clock period in system clocks |
| quiet_i | input | Q_W | Minimum chip-select high time in system clocks |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (one cycle) |
| valid_o | output | 1 | Result valid (one cycle, with done) |
| result_o | output | RES_W | Converted code, straight binary |
| pwr_o | output | 2 | Tracked power state: 0 unknown, 1 awake, 2 light, 3 deep |

## Verification
The assertions assume that the data line changes only in reaction to a serial-clock falling edge, so it is stable when the controller samples it on the next rising edge. They also assume that start arrives as single-cycle pulses and that div_i and quiet_i do not change while a request is running. The bench's converter model reacts only at falling system-clock edges, after a serial-clock fall, and it changes the divider and quiet settings only between requests. The model also keeps its own power state. It returns the inverted code for any frame started while it is asleep or still inside its power-up window, so a missing dummy frame or a short wait shows up as a wrong result.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    PW_UNKNOWN = 2'd0,
    PW_AWAKE   = 2'd1,
    PW_NAP     = 2'd2,
    PW_SLEEP   = 2'd3
  } pw_e;

  typedef enum logic [1:0] {
    OP_DUMMY = 2'd0,
    OP_SHORT = 2'd1,
    OP_REAL  = 2'd2
  } op_e;

  typedef struct packed {
    logic       dummy;
    logic       wake_wait;
    logic [1:0] shorts;
    logic       real_conv;
  } plan_t;

  // Work list for one request, from the requested mode and the tracked state.
  function automatic plan_t make_plan(input logic [1:0] mode, input pw_e pw);
    plan_t p;
    p = '0;
    case (pw)
      PW_AWAKE: begin
        if (mode == 2'd1)      p.shorts = 2'd1;
        else if (mode == 2'd2) p.shorts = 2'd2;
        else                   p.real_conv = 1'b1;
      end
      PW_NAP: begin
        if (mode == 2'd2) p.shorts = 2'd1;
        else if (mode != 2'd1) begin
          p.dummy     = 1'b1;
          p.real_conv = 1'b1;
        end
      end
      PW_SLEEP: begin
        if (mode != 2'd2) begin
          p.dummy     = 1'b1;
          p.wake_wait = 1'b1;
          if (mode == 2'd1) p.shorts = 2'd1;
          else              p.real_conv = 1'b1;
        end
      end
      default: begin
        p.dummy     = 1'b1;
        p.wake_wait = 1'b1;
        if (mode == 2'd1)      p.shorts = 2'd1;
        else if (mode == 2'd2) p.shorts = 2'd2;
        else                   p.real_conv = 1'b1;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sar_rd_frame.sv
module sar_rd_frame
  import sar_rd_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int LEAD        = 2,
  parameter int TRAIL       = 4,
  parameter int SHORT_EDGES = 4,
  parameter int DIV_W       = 8,
  parameter int Q_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             full_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [Q_W-1:0]   quiet_i,
  input  logic             sdata_i,
  output logic             ready_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             fin_o,
  output logic             fin_full_o,
  output logic [RES_W-1:0] word_o
);

  localparam int FULL_EDGES = LEAD + RES_W + TRAIL;
  localparam int EC_W       = $clog2(FULL_EDGES + 1);
  localparam int HALF_W     = DIV_W - 1;
  localparam logic [EC_W-1:0] EC_FULL  = EC_W'(FULL_EDGES);
  localparam logic [EC_W-1:0] EC_SHORT = EC_W'(SHORT_EDGES);
  localparam logic [EC_W-1:0] EC_WLO   = EC_W'(LEAD);
  localparam logic [EC_W-1:0] EC_WHI   = EC_W'(LEAD + RES_W);

  typedef enum logic {FE_IDLE, FE_RUN} fe_e;

  fe_e               st_q, st_d;
  logic              cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic              fin_q, fin_d, finf_q, finf_d, full_q, full_d;
  logic [HALF_W-1:0] hc_q, hc_d, half_q, half_d, half_eff;
  logic [EC_W-1:0]   ec_q, ec_d, last_q, last_d;
  logic [RES_W-1:0]  sh_q, sh_d, word_q, word_d;
  logic [Q_W-1:0]    qc_q, qc_d, q_m1;
  logic              tick, in_win;

  assign half_eff = (div_i[DIV_W-1:1] == '0) ? HALF_W'(1) : div_i[DIV_W-1:1];
  assign q_m1     = (quiet_i == '0) ? '0 : quiet_i - 1'b1;
  assign tick     = (hc_q == '0);
  assign in_win   = (ec_q >= EC_WLO) && (ec_q < EC_WHI);
  assign ready_o  = (st_q == FE_IDLE) && (qc_q == '0);

  always_comb begin
    st_d   = st_q;
    cs_n_d = cs_n_q;
    sclk_d = sclk_q;
    hc_d   = hc_q;
    half_d = half_q;
    ec_d   = ec_q;
    last_d = last_q;
    full_d = full_q;
    sh_d   = sh_q;
    word_d = word_q;
    fin_d  = 1'b0;
    finf_d = 1'b0;
    qc_d   = (qc_q != '0) ? qc_q - 1'b1 : qc_q;
    case (st_q)
      FE_IDLE: begin
        if (go_i && ready_o) begin
          st_d   = FE_RUN;
          cs_n_d = 1'b0;
          half_d = half_eff;
          hc_d   = half_eff - 1'b1;
          ec_d   = '0;
          last_d = full_i ? EC_FULL : EC_SHORT;
          full_d = full_i;
        end
      end
      default: begin
        if (!tick) begin
          hc_d = hc_q - 1'b1;
        end else begin
          hc_d = half_q - 1'b1;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            if (in_win) sh_d = {sh_q[RES_W-2:0], sdata_i};
          end else if (ec_q != last_q) begin
            sclk_d = 1'b0;
            ec_d   = ec_q + 1'b1;
          end else begin
            cs_n_d = 1'b1;
            st_d   = FE_IDLE;
            fin_d  = 1'b1;
            finf_d = full_q;
            qc_d   = q_m1;
            if (full_q) word_d = sh_q;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FE_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b1;
      hc_q   <= '0;
      half_q <= '0;
      ec_q   <= '0;
      last_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      word_q <= '0;
      fin_q  <= 1'b0;
      finf_q <= 1'b0;
      qc_q   <= '0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= cs_n_d;
      sclk_q <= sclk_d;
      hc_q   <= hc_d;
      half_q <= half_d;
      ec_q   <= ec_d;
      last_q <= last_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      fin_q  <= fin_d;
      finf_q <= finf_d;
      qc_q   <= qc_d;
    end
  end

  assign cs_n_o     = cs_n_q;
  assign sclk_o     = sclk_q;
  assign fin_o      = fin_q;
  assign fin_full_o = finf_q;
  assign word_o     = word_q;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q);

  // R3
  edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (ec_q == EC_FULL || ec_q == EC_SHORT));

  // R9
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> ($past(qc_q) == '0));

endmodule

// File: rtl/sar_rd_power.sv
module sar_rd_power
  import sar_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fin_i,
  input  logic fin_full_i,
  output pw_e  pw_o
);

  pw_e pw_q, pw_d;

  always_comb begin
    pw_d = pw_q;
    if (fin_i) begin
      if (fin_full_i)          pw_d = PW_AWAKE;
      else if (pw_q == PW_NAP) pw_d = PW_SLEEP;
      else                     pw_d = PW_NAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_q <= PW_UNKNOWN;
    else        pw_q <= pw_d;
  end

  assign pw_o = pw_q;

  // R10
  pw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(pw_q));

endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int PWRUP_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  pw_e              pw_i,
  input  logic             fe_ready_i,
  input  logic             fin_i,
  input  logic [RES_W-1:0] word_i,
  output logic             go_o,
  output logic             full_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);

  localparam int WC_W = $clog2(PWRUP_CYC + 1);
  localparam logic [WC_W-1:0] WC_LOAD = WC_W'(PWRUP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_FRAME, S_WAIT} sq_e;

  sq_e              st_q, st_d;
  plan_t            plan_q, plan_d;
  op_e              cur_q, cur_d;
  logic [WC_W-1:0]  wc_q, wc_d;
  logic             done_q, done_d, valid_q, valid_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             has_op;

  assign has_op = plan_q.dummy || (plan_q.shorts != 2'd0) || plan_q.real_conv;
  assign go_o   = (st_q == S_ISSUE) && has_op && fe_ready_i;
  assign full_o = plan_q.dummy || (plan_q.shorts == 2'd0);

  always_comb begin
    st_d    = st_q;
    plan_d  = plan_q;
    cur_d   = cur_q;
    wc_d    = wc_q;
    res_d   = res_q;
    done_d  = 1'b0;
    valid_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          plan_d = make_plan(mode_i, pw_i);
          st_d   = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (!has_op) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (go_o) begin
          st_d = S_FRAME;
          if (plan_q.dummy) begin
            cur_d        = OP_DUMMY;
            plan_d.dummy = 1'b0;
          end else if (plan_q.shorts != 2'd0) begin
            cur_d         = OP_SHORT;
            plan_d.shorts = plan_q.shorts - 2'd1;
          end else begin
            cur_d            = OP_REAL;
            plan_d.real_conv = 1'b0;
          end
        end
      end
      S_FRAME: begin
        if (fin_i) begin
          if (cur_q == OP_REAL) begin
            res_d   = word_i;
            valid_d = 1'b1;
            done_d  = 1'b1;
            st_d    = S_IDLE;
          end else if (cur_q == OP_DUMMY && plan_q.wake_wait) begin
            plan_d.wake_wait = 1'b0;
            wc_d             = WC_LOAD;
            st_d             = S_WAIT;
          end else begin
            st_d = S_ISSUE;
          end
        end
      end
      default: begin
        if (wc_q == '0) st_d = S_ISSUE;
        else            wc_d = wc_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      plan_q  <= '0;
      cur_q   <= OP_DUMMY;
      wc_q    <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      st_q    <= st_d;
      plan_q  <= plan_d;
      cur_q   <= cur_d;
      wc_q    <= wc_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign valid_o  = valid_q;
  assign result_o = res_q;

  // R12
  valid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> done_q);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(res_q));

  // R11
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> busy_o);

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int LEAD        = 2,
  parameter int TRAIL       = 4,
  parameter int SHORT_EDGES = 4,
  parameter int DIV_W       = 8,
  parameter int Q_W         = 8,
  parameter int PWRUP_CYC   = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [Q_W-1:0]   quiet_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic [1:0]       pwr_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             go, full, fe_ready, fin, fin_full;
  logic [RES_W-1:0] word;
  pw_e              pw;

  sar_rd_frame #(
    .RES_W(RES_W), .LEAD(LEAD), .TRAIL(TRAIL), .SHORT_EDGES(SHORT_EDGES),
    .DIV_W(DIV_W), .Q_W(Q_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n_s), .go_i(go), .full_i(full), .div_i(div_i),
    .quiet_i(quiet_i), .sdata_i(sdata_i), .ready_o(fe_ready), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .fin_o(fin), .fin_full_o(fin_full), .word_o(word)
  );

  sar_rd_power u_power (
    .clk(clk), .rst_n(rst_n_s), .fin_i(fin), .fin_full_i(fin_full), .pw_o(pw)
  );

  sar_rd_seq #(.RES_W(RES_W), .PWRUP_CYC(PWRUP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .mode_i(mode_i),
    .pw_i(pw), .fe_ready_i(fe_ready), .fin_i(fin), .word_i(word),
    .go_o(go), .full_o(full), .busy_o(busy_o), .done_o(done_o),
    .valid_o(valid_o), .result_o(result_o)
  );

  assign pwr_o = pw;

endmodule

// File: tb/sar_readout_ctrl_bench.sv
`timescale 1ns/1ps
module sar_readout_ctrl_bench;

  localparam int PWR = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] mode_r;
  logic [7:0] div_r, quiet_r;
  logic       sd;
  logic       cs_n, sclk, busy, done, valid;
  logic [9:0] result;
  logic [1:0] pwr;

  always #2.5 clk = ~clk;

  sar_readout_ctrl #(.PWRUP_CYC(PWR)) u_sar_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode_r),
    .div_i(div_r), .quiet_i(quiet_r), .sdata_i(sd), .cs_n_o(cs_n),
    .sclk_o(sclk), .busy_o(busy), .done_o(done), .valid_o(valid),
    .result_o(result), .pwr_o(pwr)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  // converter model, evaluated on falling system clock edges
  int         cyc = 0, edges = 0, rise_cyc = 0, ready_cyc = 0, f1 = 0;
  int         m_pw = 3;
  bit         prev_short = 1'b0;
  logic [15:0] word = '0;
  logic [9:0] m_code = '0;
  logic       pcs = 1'b1, psclk = 1'b1;
  int         nlog = 0;
  int         lg_e [8];
  int         lg_gap [8];
  int         lg_fg [8];

  initial sd = 1'bz;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pcs && !cs_n) begin
        if (nlog < 8) lg_gap[nlog] = cyc - rise_cyc;
        edges = 0;
        if (m_pw == 1 && cyc >= ready_cyc) word = {2'b00, m_code, 4'b0000};
        else                               word = {2'b00, ~m_code, 4'b0000};
        if (m_pw == 3) ready_cyc = cyc + PWR;
        sd = word[15];
      end else if (!pcs && cs_n) begin
        if (nlog < 8) lg_e[nlog] = edges;
        nlog++;
        if (edges >= 16) begin
          m_pw = 1; prev_short = 1'b0;
        end else if (edges >= 2 && edges < 10) begin
          m_pw = prev_short ? 3 : 2; prev_short = 1'b1;
        end else begin
          m_pw = 1; prev_short = 1'b0;
        end
        rise_cyc = cyc;
        sd = 1'bz;
      end else if (!cs_n && psclk && !sclk) begin
        edges++;
        if (edges == 1) f1 = cyc;
        if (edges == 2 && nlog < 8) lg_fg[nlog] = cyc - f1;
        sd = (edges < 16) ? word[15-edges] : 1'bz;
      end
    end else begin
      rise_cyc = cyc;
    end
    pcs = cs_n;
    psclk = sclk;
  end

  int         got_done, got_valid;
  logic [9:0] got_res;

  task automatic run_req(input logic [1:0] m, input logic [9:0] code);
    nlog = 0;
    m_code = code;
    got_done = 0; got_valid = 0;
    @(negedge clk);
    mode_r = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin
        got_done = 1; got_valid = valid; got_res = result;
        break;
      end
      if (valid) chk("R12 valid without done", 1, 0);
      @(negedge clk);
    end
    chk("R12 done seen", got_done, 1);
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
    chk("R12 valid one cycle", int'(valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sclk", int'(sclk), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 pwr", int'(pwr), 0);
  endtask

  task automatic t_first_conv;
    run_req(2'd0, 10'h2A5);
    chk("R8 frames", nlog, 2);
    chk("R8 dummy edges", lg_e[0], 16);
    chk("R3 edges", lg_e[1], 16);
    chk_ge("R8 wake gap", lg_gap[1], PWR);
    chk("R4 valid", got_valid, 1);
    chk("R4 result", int'(got_res), 'h2A5);
    chk("R8 pwr awake", int'(pwr), 1);
  endtask

  task automatic t_divs;
    int dv [4] = '{2, 6, 5, 12};
    for (int i = 0; i < 4; i++) begin
      logic [9:0] c;
      c = 10'(10'h31 * (i + 3) + i);
      div_r = 8'(dv[i]);
      run_req(2'd3, c);
      chk("R4 frames", nlog, 1);
      chk("R3 edges", lg_e[0], 16);
      chk("R2 sclk period", lg_fg[0], 2 * ((dv[i] / 2 < 1) ? 1 : dv[i] / 2));
      chk("R4 result", int'(got_res), int'(c));
    end
    div_r = 8'd2;
    run_req(2'd0, 10'h3FF);
    chk("R3 all ones", int'(got_res), 'h3FF);
    run_req(2'd0, 10'h000);
    chk("R3 all zeros", int'(got_res), 0);
  endtask

  task automatic t_nap;
    run_req(2'd1, 10'h0);
    chk("R5 frames", nlog, 1);
    chk("R5 edges", lg_e[0], 4);
    chk("R5 no valid", got_valid, 0);
    chk("R5 pwr nap", int'(pwr), 2);
    run_req(2'd1, 10'h0);
    chk("R10 nap again frames", nlog, 0);
    chk("R10 nap again valid", got_valid, 0);
    chk("R10 nap again pwr", int'(pwr), 2);
  endtask

  task automatic t_wake_nap;
    quiet_r = 8'd40;
    run_req(2'd0, 10'h1C3);
    chk("R7 frames", nlog, 2);
    chk("R7 dummy edges", lg_e[0], 16);
    chk("R7 real edges", lg_e[1], 16);
    chk_ge("R9 quiet gap", lg_gap[1], 40);
    chk("R7 result", int'(got_res), 'h1C3);
    chk("R7 valid", got_valid, 1);
    quiet_r = 8'd0;
  endtask

  task automatic t_sleep;
    run_req(2'd2, 10'h0);
    chk("R6 frames", nlog, 2);
    chk("R6 edges a", lg_e[0], 4);
    chk("R6 edges b", lg_e[1], 4);
    chk("R6 pwr sleep", int'(pwr), 3);
    chk("R6 model sleep", m_pw, 3);
    run_req(2'd2, 10'h0);
    chk("R10 sleep again frames", nlog, 0);
    chk("R10 sleep again pwr", int'(pwr), 3);
  endtask

  task automatic t_wake_sleep;
    run_req(2'd0, 10'h256);
    chk("R8 frames", nlog, 2);
    chk_ge("R8 wake gap", lg_gap[1], PWR);
    chk("R8 result", int'(got_res), 'h256);
    chk("R8 pwr", int'(pwr), 1);
  endtask

  task automatic t_nap_to_sleep;
    run_req(2'd1, 10'h0);
    run_req(2'd2, 10'h0);
    chk("R6 frames from nap", nlog, 1);
    chk("R6 edges from nap", lg_e[0], 4);
    chk("R6 pwr from nap", int'(pwr), 3);
  endtask

  task automatic t_busy;
    div_r = 8'd12;
    nlog = 0;
    m_code = 10'h0F0;
    @(negedge clk);
    mode_r = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    mode_r = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode_r = 2'd0;
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    chk("R11 result", int'(result), 'h0F0);
    repeat (100) @(negedge clk);
    chk("R11 frames", nlog, 1);
    chk("R11 busy", int'(busy), 0);
    chk("R11 pwr", int'(pwr), 1);
    div_r = 8'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_r = 2'd0; div_r = 8'd2; quiet_r = 8'd0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_first_conv;
    t_divs;
    t_nap;
    t_wake_nap;
    t_sleep;
    t_wake_sleep;
    t_nap_to_sleep;
    t_wake_sleep;
    t_busy;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule